// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the byte-wide register front end of an eight-line interrupt controller. Software talks to it through two addresses. It decodes the initialization word sequence and the run-time command words. It holds the mask, the base vector and the mode flags, and it returns read data. Request capture, the in-service vector and the priority scan live in a separate core. That core gives this block its request and in-service vectors. It also gives two resolver results: the pending line that would be delivered now, and the highest-priority line in service. In return the block sends one-cycle control pulses that clear or set in-service bits, acknowledge a polled line, load the rotation offset and wipe the core at initialization.

Initialization is a small state machine, and the number of data words it expects depends on the first word. The states are:
- READY: normal operation; an address-1 write loads the mask.
- WAIT_BASE: expects the base vector word.
- WAIT_CASCADE: expects the cascade word, which is accepted and discarded.
- WAIT_MODE: expects the mode word.

The transitions are:
- start, from any state to WAIT_BASE.
- base_to_cascade, when not in single mode.
- base_to_mode, in single mode with the fourth word requested.
- base_to_ready, in single mode with no fourth word.
- cascade_to_mode, with the fourth word requested.
- cascade_to_ready, with no fourth word.
- mode_to_ready, after the mode word.

Register updates, read data and control pulses all appear in the cycle after the strobe edge. Each pulse lasts one cycle. Write and read strobes are one cycle wide and never active together.

Top module: `irq_cmd_decoder`

## Requirements
- R1: After reset these outputs are all zero: mask, base vector, mode flags, read data and every control pulse. The machine is in READY with request readback selected and no poll pending.
- R2: An address-0 write with bit 4 = 1 starts initialization. It clears the mask, the base vector, all four mode flags, the read select (back to request) and any pending poll. It pulses init_clr and loads rotation offset 0 (rot_set = 1, rot_val = 0). It latches bit 0 as "fourth word needed" and bit 1 as "single mode", and it enters WAIT_BASE.
- R3: In WAIT_BASE an address-1 write loads base_vec from data bits 7:3. The next state is WAIT_CASCADE if single mode is clear. In single mode it is WAIT_MODE if the fourth word was requested, and READY if it was not.
- R4: In WAIT_CASCADE an address-1 write changes no register output. It moves to WAIT_MODE if the fourth word was requested, and to READY otherwise.
- R5: In WAIT_MODE an address-1 write sets fully_nested from bit 4 and auto_eoi from bit 1, then returns to READY.
- R6: In READY an address-1 write loads all eight data bits into mask.
- R7: An address-0 write with bit 4 = 0 and bit 3 = 1 is a select word; it produces no control pulse. Bit 2 = 1 makes a poll pending. Bit 1 = 1 loads the read select from bit 0 (1 = in-service, 0 = request). Bit 6 = 1 loads special_mask from bit 5. When bit 1 or bit 6 is 0, the field it enables is left unchanged.
- R8: An address-0 write with bits 4 and 3 both 0 is a command word with code = bits 7:5. Code 0 clears rot_on_aeoi and code 4 sets it. Code 2 changes no output and produces no pulse.
- R9: Codes 1 and 5 clear the highest-priority in-service line reported by the core (one-hot isr_clr). Code 5 also loads rot_val = (line + 1) mod 8. If the core reports nothing in service, neither code produces a pulse.
- R10: Code 3 clears the in-service bit named by data bits 2:0. Code 7 clears that bit and loads rot_val = (named + 1) mod 8. Code 6 loads rot_val = (bits 2:0 + 1) mod 8 and clears nothing.
- R11: A read while a poll is pending and the core reports a pending line returns 0x80 | line and pulses ack with ack_line = line. With nothing pending the read returns 0x00 and pulses nothing. Either way the poll is then cleared.
- R12: A read with no poll pending returns the mask at address 1. At address 0 it returns the in-service vector if the read select is 1 and the request vector if it is 0.
- R13: A polled acknowledge pulses isr_set for the line when auto_eoi is 0. When auto_eoi is 1 it sets no in-service bit. If rot_on_aeoi is also 1, it loads rot_val = (line + 1) mod 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe |
| addr | input | 1 | Register address (0 or 1) |
| wdata | input | 8 | Write data |
| req_vec | input | 8 | Request vector from the core |
| isr_vec | input | 8 | In-service vector from the core |
| pend_valid | input | 1 | Core has a deliverable pending line |
| pend_line | input | 3 | That pending line |
| top_valid | input | 1 | Core has at least one line in service |
| top_line | input | 3 | Highest-priority in-service line |
| rdata | output | 8 | Read data, updated the cycle after a read |
| mask | output | 8 | Mask register |
| base_vec | output | 5 | Base vector (upper five bits) |
| fully_nested | output | 1 | Special fully nested mode |
| auto_eoi | output | 1 | Automatic end-of-interrupt mode |
| rot_on_aeoi | output | 1 | Rotate on automatic end-of-interrupt |
| special_mask | output | 1 | Special mask mode |
| init_clr | output | 1 | Pulse: core clears its request and in-service vectors |
| isr_clr | output | 8 | Pulse: one-hot in-service clear |
| isr_set | output | 8 | Pulse: one-hot in-service set on acknowledge |
| ack | output | 1 | Pulse: polled line acknowledged |
| ack_line | output | 3 | Acknowledged line, valid with ack |
| rot_set | output | 1 | Pulse: load rotation offset |
| rot_val | output | 3 | New rotation offset, valid with rot_set |

## Verification
Directed sequences take initialization down all three paths: cascade with mode word, single with mode word, and single without. The bench tells them apart only by whether the next address-1 write lands in the mask, the base or the mode flags. The command words are tried with the core reporting "nothing in service" and with a valid top line. This separates the priority-driven clears, which depend on the core, from the named clears, which depend on the data bits. Constrained random traffic mixes init starts, select words, every command code and both kinds of read against random core vectors. It exposes wrong field positions, enables that leak into fields they should not touch, and poll reads that fail to clear the poll or that acknowledge with the wrong in-service or rotation effect under the auto-EOI mode.

// File: rtl/icd_pkg.sv
package icd_pkg;

    typedef enum logic [1:0] {
        ST_READY        = 2'd0,
        ST_WAIT_BASE    = 2'd1,
        ST_WAIT_CASCADE = 2'd2,
        ST_WAIT_MODE    = 2'd3
    } icd_state_e;

    localparam logic [2:0] CMD_RAEOI_OFF    = 3'd0;
    localparam logic [2:0] CMD_EOI_TOP      = 3'd1;
    localparam logic [2:0] CMD_NOP          = 3'd2;
    localparam logic [2:0] CMD_EOI_LINE     = 3'd3;
    localparam logic [2:0] CMD_RAEOI_ON     = 3'd4;
    localparam logic [2:0] CMD_ROT_EOI_TOP  = 3'd5;
    localparam logic [2:0] CMD_SET_ROT      = 3'd6;
    localparam logic [2:0] CMD_ROT_EOI_LINE = 3'd7;

endpackage

// File: rtl/icd_seq.sv
module icd_seq
    import icd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       start_need4,
    input  logic       start_single,
    input  logic       adv,
    output icd_state_e state,
    output logic       ld_mask,
    output logic       ld_base,
    output logic       ld_mode
);

    icd_state_e nxt;
    logic       need4_q;
    logic       single_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_READY;
            need4_q  <= 1'b0;
            single_q <= 1'b0;
        end else if (start) begin
            state    <= ST_WAIT_BASE;
            need4_q  <= start_need4;
            single_q <= start_single;
        end else begin
            state <= nxt;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        if (adv) begin
            unique case (state)
                ST_READY:        nxt = ST_READY;
                ST_WAIT_BASE:    nxt = single_q ? (need4_q ? ST_WAIT_MODE : ST_READY)
                                                : ST_WAIT_CASCADE;
                ST_WAIT_CASCADE: nxt = need4_q ? ST_WAIT_MODE : ST_READY;
                ST_WAIT_MODE:    nxt = ST_READY;
            endcase
        end
    end

    // outputs
    always_comb begin
        ld_mask = 1'b0;
        ld_base = 1'b0;
        ld_mode = 1'b0;
        unique case (state)
            ST_READY:        ld_mask = adv;
            ST_WAIT_BASE:    ld_base = adv;
            ST_WAIT_CASCADE: ;
            ST_WAIT_MODE:    ld_mode = adv;
        endcase
    end

    // R3: branch after the base word
    a_r3_base_branch: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_BASE && adv && !start && !single_q) |=> (state == ST_WAIT_CASCADE));

    // R4: branch after the cascade word
    a_r4_cascade_branch: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_CASCADE && adv && !start) |=>
            (state == ($past(need4_q) ? ST_WAIT_MODE : ST_READY)));

    // R2: a start always lands in WAIT_BASE
    a_r2_start_state: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state == ST_WAIT_BASE));

endmodule

// File: rtl/icd_cmd.sv
module icd_cmd
    import icd_pkg::*;
#(
    parameter int DW    = 8,
    parameter int LINES = 8,
    localparam int LW   = $clog2(LINES)
) (
    input  logic             wr0,
    input  logic [DW-1:0]    wdata,
    input  logic             top_valid,
    input  logic [LW-1:0]    top_line,
    output logic             is_init,
    output logic             poll_req,
    output logic             rsel_we,
    output logic             rsel_val,
    output logic             smm_we,
    output logic             smm_val,
    output logic             raeoi_we,
    output logic             raeoi_val,
    output logic [LINES-1:0] clr_vec,
    output logic             rot_we,
    output logic [LW-1:0]    rot_val
);

    logic          is_sel;
    logic          is_cmd;
    logic [2:0]    code;
    logic [LW-1:0] named;
    logic          clr_en;
    logic [LW-1:0] clr_line;

    assign code  = wdata[7:5];
    assign named = wdata[LW-1:0];

    always_comb begin
        is_init   = wr0 && wdata[4];
        is_sel    = wr0 && !wdata[4] && wdata[3];
        is_cmd    = wr0 && !wdata[4] && !wdata[3];
        poll_req  = is_sel && wdata[2];
        rsel_we   = is_sel && wdata[1];
        rsel_val  = wdata[0];
        smm_we    = is_sel && wdata[6];
        smm_val   = wdata[5];
        raeoi_we  = 1'b0;
        raeoi_val = 1'b0;
        clr_en    = 1'b0;
        clr_line  = '0;
        rot_we    = 1'b0;
        rot_val   = '0;
        if (is_cmd) begin
            unique case (code)
                CMD_RAEOI_OFF:    begin raeoi_we = 1'b1; raeoi_val = 1'b0; end
                CMD_RAEOI_ON:     begin raeoi_we = 1'b1; raeoi_val = 1'b1; end
                CMD_EOI_TOP:      begin clr_en = top_valid; clr_line = top_line; end
                CMD_ROT_EOI_TOP:  begin
                    clr_en   = top_valid;
                    clr_line = top_line;
                    rot_we   = top_valid;
                    rot_val  = LW'(top_line + 1'b1);
                end
                CMD_EOI_LINE:     begin clr_en = 1'b1; clr_line = named; end
                CMD_SET_ROT:      begin rot_we = 1'b1; rot_val = LW'(named + 1'b1); end
                CMD_ROT_EOI_LINE: begin
                    clr_en   = 1'b1;
                    clr_line = named;
                    rot_we   = 1'b1;
                    rot_val  = LW'(named + 1'b1);
                end
                CMD_NOP:          ;
            endcase
        end
    end

    for (genvar g = 0; g < LINES; g++) begin : g_clr
        assign clr_vec[g] = clr_en && (clr_line == LW'(g));
    end

endmodule

// File: rtl/icd_rdmux.sv
module icd_rdmux #(
    parameter int DW    = 8,
    parameter int LINES = 8,
    localparam int LW   = $clog2(LINES)
) (
    input  logic          poll,
    input  logic          addr,
    input  logic          rsel,
    input  logic          pend_valid,
    input  logic [LW-1:0] pend_line,
    input  logic [DW-1:0] req_vec,
    input  logic [DW-1:0] isr_vec,
    input  logic [DW-1:0] mask,
    output logic [DW-1:0] rd_val,
    output logic          take
);

    always_comb begin
        take = 1'b0;
        if (poll) begin
            if (pend_valid) begin
                rd_val = {1'b1, {(DW-1-LW){1'b0}}, pend_line};
                take   = 1'b1;
            end else begin
                rd_val = '0;
            end
        end else if (addr) begin
            rd_val = mask;
        end else begin
            rd_val = rsel ? isr_vec : req_vec;
        end
    end

endmodule

// File: rtl/irq_cmd_decoder.sv
module irq_cmd_decoder
    import icd_pkg::*;
#(
    parameter int DW    = 8,
    parameter int LINES = 8,
    localparam int LW   = $clog2(LINES),
    localparam int BW   = DW - LW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             addr,
    input  logic [DW-1:0]    wdata,
    input  logic [LINES-1:0] req_vec,
    input  logic [LINES-1:0] isr_vec,
    input  logic             pend_valid,
    input  logic [LW-1:0]    pend_line,
    input  logic             top_valid,
    input  logic [LW-1:0]    top_line,
    output logic [DW-1:0]    rdata,
    output logic [LINES-1:0] mask,
    output logic [BW-1:0]    base_vec,
    output logic             fully_nested,
    output logic             auto_eoi,
    output logic             rot_on_aeoi,
    output logic             special_mask,
    output logic             init_clr,
    output logic [LINES-1:0] isr_clr,
    output logic [LINES-1:0] isr_set,
    output logic             ack,
    output logic [LW-1:0]    ack_line,
    output logic             rot_set,
    output logic [LW-1:0]    rot_val
);

    logic             wr0;
    logic             wr1;
    logic             is_init, poll_req, rsel_we, rsel_val, smm_we, smm_val;
    logic             raeoi_we, raeoi_val, cmd_rot_we;
    logic [LINES-1:0] cmd_clr;
    logic [LW-1:0]    cmd_rot_val;
    icd_state_e       state;
    logic             ld_mask, ld_base, ld_mode;
    logic             rsel_q, poll_q;
    logic [DW-1:0]    rd_val;
    logic             take;

    assign wr0 = wr_en && !addr;
    assign wr1 = wr_en && addr;

    icd_cmd #(.DW(DW), .LINES(LINES)) u_cmd (
        .wr0(wr0), .wdata(wdata), .top_valid(top_valid), .top_line(top_line),
        .is_init(is_init), .poll_req(poll_req), .rsel_we(rsel_we), .rsel_val(rsel_val),
        .smm_we(smm_we), .smm_val(smm_val), .raeoi_we(raeoi_we), .raeoi_val(raeoi_val),
        .clr_vec(cmd_clr), .rot_we(cmd_rot_we), .rot_val(cmd_rot_val)
    );

    icd_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(is_init), .start_need4(wdata[0]),
        .start_single(wdata[1]), .adv(wr1), .state(state),
        .ld_mask(ld_mask), .ld_base(ld_base), .ld_mode(ld_mode)
    );

    icd_rdmux #(.DW(DW), .LINES(LINES)) u_rd (
        .poll(poll_q), .addr(addr), .rsel(rsel_q), .pend_valid(pend_valid),
        .pend_line(pend_line), .req_vec(req_vec), .isr_vec(isr_vec), .mask(mask),
        .rd_val(rd_val), .take(take)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata        <= '0;
            mask         <= '0;
            base_vec     <= '0;
            fully_nested <= 1'b0;
            auto_eoi     <= 1'b0;
            rot_on_aeoi  <= 1'b0;
            special_mask <= 1'b0;
            rsel_q       <= 1'b0;
            poll_q       <= 1'b0;
            init_clr     <= 1'b0;
            isr_clr      <= '0;
            isr_set      <= '0;
            ack          <= 1'b0;
            ack_line     <= '0;
            rot_set      <= 1'b0;
            rot_val      <= '0;
        end else begin
            init_clr <= 1'b0;
            isr_clr  <= '0;
            isr_set  <= '0;
            ack      <= 1'b0;
            rot_set  <= 1'b0;
            if (rd_en) begin
                rdata  <= rd_val;
                poll_q <= 1'b0;
                if (take) begin
                    ack      <= 1'b1;
                    ack_line <= pend_line;
                    if (!auto_eoi) begin
                        isr_set <= LINES'(1) << pend_line;
                    end else if (rot_on_aeoi) begin
                        rot_set <= 1'b1;
                        rot_val <= LW'(pend_line + 1'b1);
                    end
                end
            end
            if (is_init) begin
                mask         <= '0;
                base_vec     <= '0;
                fully_nested <= 1'b0;
                auto_eoi     <= 1'b0;
                rot_on_aeoi  <= 1'b0;
                special_mask <= 1'b0;
                rsel_q       <= 1'b0;
                poll_q       <= 1'b0;
                init_clr     <= 1'b1;
                rot_set      <= 1'b1;
                rot_val      <= '0;
            end else begin
                if (poll_req) poll_q <= 1'b1;
                if (rsel_we)  rsel_q <= rsel_val;
                if (smm_we)   special_mask <= smm_val;
                if (raeoi_we) rot_on_aeoi  <= raeoi_val;
                if (wr0) isr_clr <= cmd_clr;
                if (cmd_rot_we) begin
                    rot_set <= 1'b1;
                    rot_val <= cmd_rot_val;
                end
                if (ld_mask) mask     <= wdata;
                if (ld_base) base_vec <= wdata[DW-1:LW];
                if (ld_mode) begin
                    fully_nested <= wdata[4];
                    auto_eoi     <= wdata[1];
                end
            end
        end
    end

    // R2: initialization clears the mask and modes and pulses init_clr
    a_r2_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr0 && wdata[4]) |=> (mask == '0 && init_clr && rot_set && rot_val == '0
                               && !auto_eoi && !special_mask));

    // R6: mask load in READY
    a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr1 && state == ST_READY) |=> (mask == $past(wdata)));

    // R8: code 2 produces no pulse
    a_r8_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wr0 && wdata[4:3] == 2'b00 && wdata[7:5] == CMD_NOP) |=>
            (isr_clr == '0 && !rot_set && !init_clr));

    // R9: priority clear with nothing in service does nothing
    a_r9_no_top_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr0 && wdata[4:3] == 2'b00 && (wdata[7:5] == CMD_EOI_TOP || wdata[7:5] == CMD_ROT_EOI_TOP)
         && !top_valid) |=> (isr_clr == '0 && !rot_set));

    // R11: any read leaves no poll pending
    a_r11_poll_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> !poll_q);

    // R13: auto-EOI acknowledge sets no in-service bit
    a_r13_aeoi_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && auto_eoi) |=> (isr_set == '0));

endmodule

// File: tb/sim_irq_cmd_decoder.sv
module sim_irq_cmd_decoder;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
    logic [7:0] wdata = '0, req_vec = '0, isr_vec = '0;
    logic       pend_valid = 1'b0, top_valid = 1'b0;
    logic [2:0] pend_line = '0, top_line = '0;
    logic [7:0] rdata, mask, isr_clr, isr_set;
    logic [4:0] base_vec;
    logic       fully_nested, auto_eoi, rot_on_aeoi, special_mask, init_clr, ack, rot_set;
    logic [2:0] ack_line, rot_val;

    int n_cmp = 0;
    int n_bad = 0;

    // reference state
    logic [7:0] m_mask = '0, m_rdata = '0;
    logic [4:0] m_base = '0;
    logic m_fn = 0, m_ae = 0, m_ra = 0, m_sm = 0, m_rsel = 0, m_poll = 0;
    logic m_n4 = 0, m_sg = 0;
    int   m_st = 0;
    logic [7:0] e_clr, e_set;
    logic e_ack, e_rot, e_init;
    logic [2:0] e_ackl, e_rotv;
    string t_rot, t_clr, t_rd;

    irq_cmd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .req_vec(req_vec), .isr_vec(isr_vec), .pend_valid(pend_valid), .pend_line(pend_line),
        .top_valid(top_valid), .top_line(top_line), .rdata(rdata), .mask(mask),
        .base_vec(base_vec), .fully_nested(fully_nested), .auto_eoi(auto_eoi),
        .rot_on_aeoi(rot_on_aeoi), .special_mask(special_mask), .init_clr(init_clr),
        .isr_clr(isr_clr), .isr_set(isr_set), .ack(ack), .ack_line(ack_line),
        .rot_set(rot_set), .rot_val(rot_val)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // compute expectations for one strobe from the requirements
    task automatic model(logic w, logic r, logic a, logic [7:0] d);
        e_clr = '0; e_set = '0; e_ack = 0; e_rot = 0; e_init = 0; e_ackl = '0; e_rotv = '0;
        t_rot = "R10 rot"; t_clr = "R10 clr";
        if (r) begin
            if (m_poll) begin
                t_rd = "R11 poll rdata";
                if (pend_valid) begin
                    m_rdata = 8'h80 | {5'd0, pend_line};
                    e_ack = 1; e_ackl = pend_line;
                    if (!m_ae) e_set = 8'd1 << pend_line;
                    else if (m_ra) begin e_rot = 1; e_rotv = pend_line + 3'd1; t_rot = "R13 rot"; end
                end else m_rdata = 8'h00;
                m_poll = 0;
            end else begin
                t_rd = "R12 rdata";
                m_rdata = a ? m_mask : (m_rsel ? isr_vec : req_vec);
            end
        end
        if (w && !a && d[4]) begin
            m_mask = 0; m_base = 0; m_fn = 0; m_ae = 0; m_ra = 0; m_sm = 0; m_rsel = 0; m_poll = 0;
            e_init = 1; e_rot = 1; e_rotv = 0; t_rot = "R2 rot";
            m_st = 1; m_n4 = d[0]; m_sg = d[1];
        end else if (w && !a && d[3]) begin
            if (d[2]) m_poll = 1;
            if (d[1]) m_rsel = d[0];
            if (d[6]) m_sm = d[5];
        end else if (w && !a) begin
            case (d[7:5])
                3'd0: m_ra = 0;
                3'd4: m_ra = 1;
                3'd1, 3'd5: begin
                    t_clr = "R9 clr"; t_rot = "R9 rot";
                    if (top_valid) begin
                        e_clr = 8'd1 << top_line;
                        if (d[7:5] == 3'd5) begin e_rot = 1; e_rotv = top_line + 3'd1; end
                    end
                end
                3'd3: e_clr = 8'd1 << d[2:0];
                3'd6: begin e_rot = 1; e_rotv = d[2:0] + 3'd1; end
                3'd7: begin e_clr = 8'd1 << d[2:0]; e_rot = 1; e_rotv = d[2:0] + 3'd1; end
                default: ;
            endcase
        end else if (w && a) begin
            case (m_st)
                0: m_mask = d;
                1: begin m_base = d[7:3]; m_st = m_sg ? (m_n4 ? 3 : 0) : 2; end
                2: m_st = m_n4 ? 3 : 0;
                default: begin m_fn = d[4]; m_ae = d[1]; m_st = 0; end
            endcase
        end
    endtask

    task automatic compare_all();
        chk("R6 mask", mask, m_mask);
        chk("R3 base", base_vec, m_base);
        chk("R5 fully_nested", fully_nested, m_fn);
        chk("R5 auto_eoi", auto_eoi, m_ae);
        chk("R8 rot_on_aeoi", rot_on_aeoi, m_ra);
        chk("R7 special_mask", special_mask, m_sm);
        chk(t_rd, rdata, m_rdata);
        chk(t_clr, isr_clr, e_clr);
        chk("R13 isr_set", isr_set, e_set);
        chk("R11 ack", ack, e_ack);
        if (e_ack) chk("R11 ack_line", ack_line, e_ackl);
        chk("R2 init_clr", init_clr, e_init);
        chk(t_rot, rot_set, e_rot);
        if (e_rot) chk(t_rot, rot_val, e_rotv);
    endtask

    task automatic step(logic w, logic r, logic a, logic [7:0] d);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d;
        model(w, r, a, d);
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        compare_all();
    endtask

    task automatic core(logic [7:0] rq, logic [7:0] is, logic pv, logic [2:0] pl, logic tv, logic [2:0] tl);
        req_vec = rq; isr_vec = is; pend_valid = pv; pend_line = pl; top_valid = tv; top_line = tl;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0C11));
        t_rd = "R12 rdata"; t_rot = "R10 rot"; t_clr = "R10 clr";
        e_clr = 0; e_set = 0; e_ack = 0; e_rot = 0; e_init = 0; e_ackl = 0; e_rotv = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 mask", mask, 8'h00);
        chk("R1 base", base_vec, 5'd0);
        chk("R1 modes", {fully_nested, auto_eoi, rot_on_aeoi, special_mask}, 4'd0);
        chk("R1 pulses", {init_clr, ack, rot_set, isr_clr, isr_set}, '0);
        chk("R1 rdata", rdata, 8'h00);
        core(8'h5A, 8'h21, 1'b0, 3'd0, 1'b0, 3'd0);
        step(0, 1, 0, 8'h00);   // request selected after reset
        chk("R1 rsel request", rdata, 8'h5A);

        // full path: cascade word and mode word
        step(1, 0, 1, 8'hF0);
        step(1, 0, 0, 8'h11);   // start, need4=1, single=0
        step(1, 0, 1, 8'hA8);   // base
        chk("R3 base load", base_vec, 5'h15);
        step(1, 0, 1, 8'hFF);   // cascade word, discarded
        chk("R4 cascade no mask load", mask, 8'h00);
        step(1, 0, 1, 8'h12);   // mode word
        chk("R5 mode word", {fully_nested, auto_eoi}, 2'b11);
        step(1, 0, 1, 8'h3C);
        chk("R6 mask after init", mask, 8'h3C);

        // single without fourth word
        step(1, 0, 0, 8'h12);
        step(1, 0, 1, 8'h40);
        step(1, 0, 1, 8'h77);
        chk("R3 single no fourth -> ready", mask, 8'h77);

        // single with fourth word
        step(1, 0, 0, 8'h13);
        step(1, 0, 1, 8'h08);
        step(1, 0, 1, 8'h02);
        chk("R5 single fourth word", auto_eoi, 1'b1);

        // command corner cases
        core(8'h00, 8'h00, 1'b0, 3'd0, 1'b0, 3'd0);
        step(1, 0, 0, 8'h20);   // code 1, nothing in service
        chk("R9 no top no clear", isr_clr, 8'h00);
        step(1, 0, 0, 8'h40);   // code 2
        chk("R8 nop quiet", {rot_set, init_clr, isr_clr}, '0);
        core(8'h00, 8'h00, 1'b0, 3'd0, 1'b1, 3'd7);
        step(1, 0, 0, 8'hA0);   // code 5 top=7
        chk("R9 rotate wrap", rot_val, 3'd0);
        step(1, 0, 0, 8'hE5);   // code 7 line 5
        chk("R10 named clear", isr_clr, 8'h20);
        step(1, 0, 0, 8'h0C);   // poll
        step(0, 1, 0, 8'h00);   // nothing pending
        chk("R11 empty poll", rdata, 8'h00);
        step(1, 0, 0, 8'h0B);   // select in-service
        core(8'h0F, 8'hC3, 1'b0, 3'd0, 1'b0, 3'd0);
        step(0, 1, 0, 8'h00);
        chk("R12 isr readback", rdata, 8'hC3);
        step(1, 0, 0, 8'h08);   // bit1=0: select unchanged
        step(0, 1, 0, 8'h00);
        chk("R7 select kept", rdata, 8'hC3);

        // constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            int op;
            logic [7:0] d;
            core(8'($urandom), 8'($urandom), 1'($urandom), 3'($urandom), 1'($urandom), 3'($urandom));
            op = $urandom % 10;
            d  = 8'($urandom);
            if ($urandom % 6 != 0) d[4] = 1'b0;
            if (op < 3)      step(1, 0, 0, d);
            else if (op < 5) step(1, 0, 1, d);
            else if (op < 8) step(0, 1, 1'($urandom), 8'h00);
            else             step(0, 0, 0, 8'h00);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule